// File: doc/BRIEF.md
# Timed Hexadecimal Up/Down Counter with Seven-Segment Output

This block holds a 4-bit count and moves it by one step per second, up or down. A prescaler runs from the fast system clock. It counts to a terminal value, and its comparator raises a single-cycle tick each time the terminal value is reached. The count is always shown on a seven-segment display as a hexadecimal glyph from 0 to F.

The controls are plain, level-sampled inputs on fixed bit positions of an 8-bit control byte. The four low bits carry a value for parallel loading. The four high bits are count enable, synchronous clear, direction and load. Clear and load act on every system clock edge. A counting step happens only on a tick. Nothing flows in or out as a stream, so the block has no valid/ready handshake and never applies back-pressure.

The outputs form an 8-bit segment byte. The seven low bits drive segments a to g, and the top bit drives the decimal point. The terminal value of the prescaler is a parameter. Its default of 9,999,999 gives one step per second from a 10 MHz clock.

Top module: `hex_timer_display`

## Requirements
- R1: The prescaler counts system clock edges from zero after reset and raises its tick once every PRESCALE_TERM+1 edges. Taking the release of reset as edge zero, enabled counting steps land on edges PRESCALE_TERM+1, 2*(PRESCALE_TERM+1), and so on.
- R2: With ctrl_in[4] (enable) high and ctrl_in[6] (direction) high, each tick adds one to the count, and F wraps to 0.
- R3: With enable high and direction low, each tick subtracts one from the count, and 0 wraps to F.
- R4: With enable low and neither clear nor load active, the count holds its value across ticks.
- R5: A high ctrl_in[5] (clear) sets the count to 0 on the next system clock edge, tick or not. Clear outranks both load and a counting step.
- R6: A high ctrl_in[7] (load) without clear writes ctrl_in[3:0] into the count on the next system clock edge. Load outranks a counting step, so a held load keeps the loaded value through ticks. Counting resumes from that value once load falls.
- R7: seg_out[6:0] is active high, with bit 0 = a through bit 6 = g. The glyph codes in {g..a} order are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R8: seg_out[7] (decimal point) is always 0.
- R9: rst_n is asynchronous and active low. While it is low, the count and the prescaler are zero and seg_out shows 8'h3F at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_in | input | 8 | [3:0] load value, [4] enable, [5] clear, [6] direction (1 = up), [7] load |
| seg_out | output | 8 | [6:0] segments a..g (active high), [7] decimal point |

## Verification
The bench drives enabled counting in both directions for more than sixteen ticks, so that both wraps occur. A design that saturated at F or at 0, or stepped by the wrong amount, would then show the wrong glyph on the step after the wrap. Loads and clears are placed between ticks and held across ticks. Clear and load are also raised together. A design that gated clear or load with the tick would miss the change between ticks, and one with the priorities swapped would show the loaded digit where a 0 belongs. Every cycle is compared against a reference, so a prescaler that is off by one edge shows up as a step in the wrong cycle. A mid-run asynchronous reset checks that the output goes dark to the 0 glyph before any clock edge and that tick timing restarts.

// File: rtl/hexcnt_pkg.sv
package hexcnt_pkg;

  typedef logic [3:0] nibble_t;

  // Control byte layout, fixed pin order (MSB first in the packed struct)
  typedef struct packed {
    logic    ld;    // bit 7
    logic    up;    // bit 6
    logic    clr;   // bit 5
    logic    en;    // bit 4
    nibble_t data;  // bits 3:0
  } ctrl_t;

endpackage

// File: rtl/hexcnt_prescaler.sv
module hexcnt_prescaler #(
  parameter int unsigned TERM = 9_999_999
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (TERM > 0) ? $clog2(TERM + 1) : 1;
  localparam logic [W-1:0] TERM_V = W'(TERM);

  logic [W-1:0] pre_q;

  // comparator: terminal count reached
  assign tick = (pre_q == TERM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  // R1
  prescale_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));

  generate
    if (TERM > 0) begin : g_gap
      // R1
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/hexcnt_core.sv
module hexcnt_core
  import hexcnt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  ctrl_t   ctrl,
  output nibble_t count
);
  nibble_t count_q;
  nibble_t stepped;
  logic    do_step;

  assign do_step = ctrl.en & tick;
  assign stepped = ctrl.up ? (count_q + 4'd1) : (count_q - 4'd1);

  // priority: clear, load, step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (ctrl.clr) count_q <= '0;
    else if (ctrl.ld)  count_q <= ctrl.data;
    else if (do_step)  count_q <= stepped;
  end

  assign count = count_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clr |=> (count == 4'd0));

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && ctrl.ld) |=> (count == $past(ctrl.data)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && !ctrl.ld && !(ctrl.en && tick)) |=> $stable(count));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && !ctrl.ld && ctrl.en && tick && ctrl.up)
      |=> (count == $past(count) + 4'd1));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && !ctrl.ld && ctrl.en && tick && !ctrl.up)
      |=> (count == $past(count) - 4'd1));

endmodule

// File: rtl/hexcnt_glyph.sv
module hexcnt_glyph
  import hexcnt_pkg::*;
(
  input  nibble_t    digit,
  output logic [6:0] seg   // {g,f,e,d,c,b,a}, active high
);
  always_comb begin
    unique case (digit)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end

  // R7
  always_comb begin
    seg_lit_chk: assert ($countones(seg) >= 2);
  end

endmodule

// File: rtl/hex_timer_display.sv
module hex_timer_display
  import hexcnt_pkg::*;
#(
  parameter int unsigned PRESCALE_TERM = 9_999_999
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_in,
  output logic [7:0] seg_out
);
  ctrl_t      ctrl;
  logic       tick;
  nibble_t    count;
  logic [6:0] seg;

  assign ctrl = ctrl_t'(ctrl_in);

  hexcnt_prescaler #(.TERM(PRESCALE_TERM)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  hexcnt_core u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .ctrl (ctrl),
    .count(count)
  );

  hexcnt_glyph u_glyph (
    .digit(count),
    .seg  (seg)
  );

  assign seg_out = {1'b0, seg};

  // R9
  reset_glyph_chk: assert property (@(posedge clk)
    !rst_n |-> (seg_out == 8'h3F));

endmodule

// File: tb/hex_timer_display_tb_top.sv
module hex_timer_display_tb_top;
  localparam int unsigned TERM = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl_in = 8'h00;
  logic [7:0] seg_out;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R9";

  typedef struct {
    logic [7:0] seg;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  hex_timer_display #(.PRESCALE_TERM(TERM)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_in(ctrl_in),
    .seg_out(seg_out)
  );

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: seg_out=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: per-edge expectation pushed into the scoreboard
  int         m_pre = 0;
  logic [3:0] m_cnt = 4'h0;
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_pre = 0;
      m_cnt = 4'h0;
    end else begin
      logic tk;
      tk = (m_pre == int'(TERM));                        // R1
      m_pre = tk ? 0 : m_pre + 1;
      if (ctrl_in[5])      m_cnt = 4'h0;                 // R5
      else if (ctrl_in[7]) m_cnt = ctrl_in[3:0];         // R6
      else if (ctrl_in[4] && tk)
        m_cnt = ctrl_in[6] ? m_cnt + 4'd1 : m_cnt - 4'd1; // R2 R3
    end
    e.seg = {1'b0, glyph(m_cnt)};
    e.tag = phase;
    sb_q.push_back(e);
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(seg_out, e.seg, e.tag);
      check({seg_out[7], 7'h0}, 8'h00, "R8 dot");
    end
  end

  task automatic drive(input logic [7:0] c, input int cycles, input string tag);
    @(negedge clk);
    phase = tag;
    ctrl_in = c;
    repeat (cycles) @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #1;
    check(seg_out, 8'h3F, "R9 reset glyph");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // ctrl: {ld, up, clr, en, data}
    drive(8'b0101_0000, 200, "R1 R2 up wrap");
    drive(8'b0001_0000, 200, "R3 down wrap");
    drive(8'b0100_0000, 60,  "R4 hold");
    drive(8'b1101_1010, 1,   "R6 load A");
    drive(8'b0101_0000, 35,  "R6 resume");
    drive(8'b1011_0111, 1,   "R5 clear over load");
    drive(8'b0101_0000, 23,  "R2 after clear");
    drive(8'b0011_0000, 1,   "R5 clear between ticks");
    drive(8'b0001_0000, 25,  "R3 after clear");
    drive(8'b1101_0101, 25,  "R6 held load over ticks");
    drive(8'b0001_0000, 33,  "R3 resume from load");
    // asynchronous reset mid-run
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(seg_out, 8'h3F, "R9 async reset");
    phase = "R9 in reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(8'b0101_0000, 45, "R1 R9 restart timing");
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule